// File: doc/BRIEF.md
# Pipelined Two-Byte Result Serializer

This block receives one 16-bit conversion result per sample clock, each with a valid flag. It passes every result through a fixed delay line and then places it on an 8-bit output bus. In the normal mode the result takes two bus slots inside one sample period. The upper byte is on the bus while the sample clock is high, and the lower byte is on the bus while the clock is low. A phase output tells the receiver which byte it is reading.

A compact mode sends only the upper byte and keeps it on the bus for the whole sample period. An active-low enable releases the bus to high impedance. The delay line keeps moving while the bus is released, so the latency never changes. Neither the mode bit nor the enable passes through the delay line. Both act at once on whichever result is currently at the end of the line.

Top module: `pix_byte_mux`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid result reaches the end of the delay line, an enabled bus shows 0x00 in both clock phases.
- R2: In two-byte mode (`one_byte`=0), the bus carries bits [15:8] of the result while `clk` is high and bits [7:0] while `clk` is low. `byte_hi` is 1 in the high phase and 0 in the low phase.
- R3: A result captured at rising edge n is presented on the bus from rising edge n+LATENCY until rising edge n+LATENCY+1. LATENCY defaults to 9, and results come out in the order they went in.
- R4: In single-byte mode (`one_byte`=1), bits [15:8] of the result stay on the bus for both clock phases and `byte_hi` stays 1.
- R5: While `oe_n`=1 the bus is high impedance. The delay line keeps advancing, so results captured while the bus was released still appear at their normal time once it is enabled again.
- R6: A slot whose result was captured with `in_valid`=0 drives 0x00 on an enabled bus in both phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; its level also selects the byte phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 16 | Conversion result |
| in_valid | input | 1 | Result qualifier |
| one_byte | input | 1 | 1 selects upper-byte-only output |
| oe_n | input | 1 | Active-low bus enable |
| dq | output | 8 | Tri-state byte bus |
| byte_hi | output | 1 | 1 when the upper byte is on the bus |

## Verification
A valid flag lost or stuck inside the delay line shows up exactly LATENCY edges later. The bus then carries 0x00 where a result was expected, or a result where 0x00 was expected. A stage skipped or repeated shifts every later result by one sample period, so the first word after the fault already mismatches. A byte-select fault appears within one half period, either as swapped or repeated bytes or as a wrong `byte_hi` level.

// File: rtl/pix_byte_mux.sv
module pix_byte_mux #(
  parameter int BYTE_W  = 8,
  parameter int LATENCY = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*BYTE_W-1:0] in_word,
  input  logic                in_valid,
  input  logic                one_byte,
  input  logic                oe_n,
  output wire  [BYTE_W-1:0]   dq,
  output logic                byte_hi
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int LAST   = LATENCY;

  logic [WORD_W-1:0] pipe_d [0:LAST];
  logic [LAST:0]     pipe_v;
  logic [WORD_W-1:0] out_w;
  logic [BYTE_W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_v <= '0;
      for (int i = 0; i <= LAST; i++) pipe_d[i] <= '0;
    end else begin
      pipe_v    <= {pipe_v[LAST-1:0], in_valid};
      pipe_d[0] <= in_word;
      for (int i = 1; i <= LAST; i++) pipe_d[i] <= pipe_d[i-1];
    end
  end

  assign out_w   = pipe_v[LAST] ? pipe_d[LAST] : '0;
  assign byte_hi = clk | one_byte;
  assign sel     = byte_hi ? out_w[WORD_W-1:BYTE_W] : out_w[BYTE_W-1:0];
  assign dq      = oe_n ? {BYTE_W{1'bz}} : sel;

  assert_flow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(pipe_v) ==
      $countones($past(pipe_v)) + $past(in_valid) - $past(pipe_v[LAST]))
    else $error("valid count in delay line broken");

  always @(negedge clk) begin
    if (rst_n && !pipe_v[LAST])
      assert_idle_R6: assert (sel == '0) else $error("idle slot not zero");
    if (rst_n && pipe_v[LAST] && !one_byte)
      assert_lo_R2: assert (sel == pipe_d[LAST][BYTE_W-1:0] && !byte_hi)
        else $error("low phase not low byte");
    if (rst_n && pipe_v[LAST] && one_byte)
      assert_hold_R4: assert (sel == pipe_d[LAST][WORD_W-1:BYTE_W] && byte_hi)
        else $error("single-byte hold broken");
  end

endmodule

// File: tb/pix_byte_mux_test.sv
module pix_byte_mux_test;
  localparam int L = 9;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] in_word = 0;
  logic        in_valid = 0;
  logic        one_byte = 0;
  logic        oe_n = 0;
  wire  [7:0]  dq;
  logic        byte_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [16:0] q[$];

  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (dq[i]);
  end

  pix_byte_mux #(.BYTE_W(8), .LATENCY(L)) uut (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .one_byte(one_byte), .oe_n(oe_n), .dq(dq), .byte_hi(byte_hi));

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s bus act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_ph(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s byte_hi act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step(logic v, logic [15:0] w, logic ob, logic oe);
    @(posedge clk);
    #1;
    in_valid = v; in_word = w; one_byte = ob; oe_n = oe;
    q.push_back({v, w});
  endtask

  // monitor: high phase at +2, low phase at +7 after each rising edge
  initial begin
    logic [16:0] cur;
    logic [7:0]  eh, el;
    string th, tl;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (q.size() == L + 2) cur = q.pop_front();
        else cur = '0;
        eh = cur[16] ? cur[15:8] : 8'h00;
        el = cur[16] ? (one_byte ? cur[15:8] : cur[7:0]) : 8'h00;
        th = oe_n ? "R5" : (!cur[16] ? "R6" : "R3");
        chk(th, dq, oe_n ? 8'hFF : eh);
        chk_ph("R2", byte_hi, 1'b1);
        #5;
        tl = oe_n ? "R5" : (!cur[16] ? "R6" : (one_byte ? "R4" : "R2"));
        if (oe_n) chk(tl, dq, 8'hFF);
        else chk(tl, dq, one_byte ? eh : el);
        chk_ph(one_byte ? "R4" : "R2", byte_hi, one_byte);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    in_word = 16'hA5C3; in_valid = 1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", dq, 8'h00); chk_ph("R1", byte_hi, 1'b1);
    #5;
    chk("R1", dq, 8'h00); chk_ph("R1", byte_hi, 1'b0);
    @(posedge clk);
    #1;
    in_valid = 0;
    rst_n = 1;

    for (int i = 0; i < 14; i++)
      step(1'b1, 16'h1234 + 16'(i * 16'h0F1D), 1'b0, 1'b0);
    for (int i = 0; i < 6; i++)
      step(i[0], 16'hC0DE ^ 16'(i), 1'b0, 1'b0);
    for (int i = 0; i < 14; i++)
      step(1'b1, 16'h8E71 + 16'(i * 16'h0303), 1'b1, 1'b0);
    for (int i = 0; i < 6; i++)
      step(1'b1, 16'h5A00 | 16'(i), 1'b0, 1'b1);
    for (int i = 0; i < 12; i++)
      step(1'b1, 16'h0F0F + 16'(i * 16'h1111), i >= 6, 1'b0);
    step(1'b1, 16'hFFFF, 1'b0, 1'b0);
    step(1'b1, 16'h0000, 1'b0, 1'b0);
    step(1'b1, 16'h00FF, 1'b0, 1'b0);
    step(1'b1, 16'hFF00, 1'b0, 1'b0);
    step(1'b1, 16'h8001, 1'b0, 1'b0);
    step(1'b0, 16'hBEEF, 1'b0, 1'b0);
    for (int i = 0; i < L + 4; i++)
      step(1'b0, 16'h0000, 1'b0, 1'b0);
    @(posedge clk);
    #9;
    finish_run();
  end
endmodule